// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries data words from a write clock domain to an unrelated read clock domain. Each side has its own enable. The write side raises `full` when no further word can be taken. The read side raises `empty` when it has nothing to give. Two active-low threshold flags warn before either limit is reached: `pae_n` near empty and `paf_n` near full. The distances from each limit come from two offset inputs that are captured while master reset is held.

Two select inputs are captured at the same time. The first picks how the flags are timed:
- **Registered:** each flag changes only on the clock edge of its own domain.
- **Direct:** each flag compares the live write and read pointers. A write edge can therefore drive it one way and a read edge the other way.

The second select picks the read style:
- **Demand read:** a word leaves only when a read is enabled.
- **Look-ahead read:** the oldest word is presented on the output ahead of any read request. The output register holds one word beyond the memory, so the usable depth grows by one word.

Pointers cross between domains as Gray code through two-flop synchronisers.

The read side has a two-state output stage:
- **OUT_EMPTY:** the output register holds nothing valid.
- **OUT_HOLD:** the output register holds a valid word.

Its transitions are:
- **LOAD (OUT_EMPTY → OUT_HOLD):** a word is fetched from memory.
- **REFILL (OUT_HOLD → OUT_HOLD):** another fetch happens in the same cycle.
- **KEEP (OUT_HOLD → OUT_HOLD):** in look-ahead mode, no read is requested.
- **DRAIN (OUT_HOLD → OUT_EMPTY):** the word is consumed or the one-cycle valid window ends, and no new fetch happens.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `mrst_n` is low, the outputs are `empty`=1, `full`=0, `pae_n`=0, `paf_n`=1 and `dout_valid`=0.
- R2: Words leave in the order they were accepted, with none lost or duplicated, in every mode combination.
- R3: Let D be 2^AW in demand mode and 2^AW+1 in look-ahead mode. `full` is 1 exactly when D words are held. A write while `full` is 1 stores nothing.
- R4: In demand mode, an accepted read loads the next word into `dout` on that read-clock edge, and `dout_valid` is 1 for the following cycle only. A read while `empty` is 1 leaves `dout` unchanged and `dout_valid` at 0.
- R5: In look-ahead mode, the oldest word appears on `dout` with `dout_valid`=1 without any read request. It stays there until `ren` is sampled high. `empty` is the inverse of `dout_valid` in this mode.
- R6: With near-empty offset n and W words held (counting the output register in look-ahead mode), `pae_n` is 0 when W ≤ n in demand mode and when W ≤ n+1 in look-ahead mode. Otherwise it is 1.
- R7: With near-full offset m, `paf_n` is 0 when W ≥ D−m and 1 otherwise.
- R8: `flag_sync_sel`=1 selects registered flags, which hold their value while their own clock is stopped. `flag_sync_sel`=0 selects direct flags:
  - `pae_n` rises right after the write edge that crosses its threshold, even with the read clock stopped.
  - `paf_n` rises right after the read edge that crosses its threshold, even with the write clock stopped.
- R9: The offsets and both selects are captured only while master reset is held, and for one edge after its release. Later changes on those inputs have no effect.
- R10: Each clock-domain crossing pointer changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| wen | input | 1 | Write enable |
| din | input | DW | Write data |
| full | output | 1 | No room for another word |
| ren | input | 1 | Read enable |
| dout | output | DW | Read data register |
| dout_valid | output | 1 | `dout` holds a valid word |
| empty | output | 1 | Nothing available to read |
| pae_off | input | AW+1 | Near-empty offset, captured at reset |
| paf_off | input | AW+1 | Near-full offset, captured at reset |
| flag_sync_sel | input | 1 | 1 selects registered flags, 0 selects direct flags |
| fwft_sel | input | 1 | 1 selects look-ahead read, 0 selects demand read |
| pae_n | output | 1 | Near-empty flag, active low |
| paf_n | output | 1 | Near-full flag, active low |

## Verification
Four configurations cover every pairing of read style and flag timing, each with different offsets. Each configuration fills the FIFO one word at a time to its limit, then drains it. At every occupancy the flags are compared with the expected values, so an error of one word in either threshold, or in the one-word depth shift, shows up. A write into a full FIFO and a read from an empty one show that neither limit is crossed. Directed runs then halt one clock and move the other. This separates registered flags, which must hold, from direct flags, which must follow the moving pointer at once.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_HOLD  = 1'b1
    } out_st_t;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_dec
            assign bin_out[g] = ^stg[STAGES-1][W-1:g];
        end
    endgenerate
endmodule

// File: rtl/dcfifo_wside.sv
module dcfifo_wside #(
    parameter int AW = 4
) (
    input  logic        wclk,
    input  logic        mrst_n,
    input  logic        wen,
    input  logic [AW:0] paf_off_in,
    input  logic        flag_sync_in,
    input  logic [AW:0] rgray,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic        wr_fire,
    output logic        full,
    output logic        paf_sync_n,
    output logic        flag_sync_q,
    output logic [AW:0] paf_off_q
);
    localparam int PW  = AW + 1;
    localparam int MEM = 1 << AW;

    logic [PW-1:0] rbin_s, wbin_nx, wcount, wcount_nx;
    logic          cfg_en;

    dcfifo_sync #(.W(PW), .STAGES(2)) u_rsync (
        .clk(wclk), .rst_n(mrst_n), .gray_in(rgray), .bin_out(rbin_s)
    );

    assign wcount    = wbin - rbin_s;
    assign full      = (wcount == PW'(MEM));
    assign wr_fire   = wen && !full;
    assign wbin_nx   = wbin + PW'(wr_fire);
    assign wcount_nx = wbin_nx - rbin_s;

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            wbin       <= '0;
            wgray      <= '0;
            paf_sync_n <= 1'b1;
            cfg_en     <= 1'b1;
        end else begin
            wbin       <= wbin_nx;
            wgray      <= wbin_nx ^ (wbin_nx >> 1);
            paf_sync_n <= !(wcount_nx >= (PW'(MEM) - paf_off_q));
            cfg_en     <= 1'b0;
        end
    end

    always_ff @(posedge wclk) begin
        if (cfg_en) begin
            paf_off_q   <= paf_off_in;
            flag_sync_q <= flag_sync_in;
        end
    end

    a_r3_count_bound: assert property (@(posedge wclk) disable iff (!mrst_n)
        wcount <= PW'(MEM));
    a_r10_wgray_step: assert property (@(posedge wclk) disable iff (!mrst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
    a_r8_paf_fall_on_write: assert property (@(posedge wclk) disable iff (!mrst_n)
        (flag_sync_q && $fell(paf_sync_n)) |-> $past(wr_fire));
endmodule

// File: rtl/dcfifo_rside.sv
module dcfifo_rside
    import dcfifo_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          ren,
    input  logic [AW:0]   pae_off_in,
    input  logic          fwft_in,
    input  logic          flag_sync_in,
    input  logic [AW:0]   wgray,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          dout_valid,
    output logic          empty,
    output logic          pae_sync_n,
    output logic          flag_sync_q,
    output logic [AW:0]   pae_off_q
);
    localparam int PW  = AW + 1;
    localparam int MEM = 1 << AW;

    logic [PW-1:0] wbin_s, rbin_nx;
    logic          mem_empty, rd_fire, fwft_q, cfg_en;
    out_st_t       st, st_nx;

    dcfifo_sync #(.W(PW), .STAGES(2)) u_wsync (
        .clk(rclk), .rst_n(mrst_n), .gray_in(wgray), .bin_out(wbin_s)
    );

    assign mem_empty = (rbin == wbin_s);
    assign rd_fire   = !mem_empty && (fwft_q ? (st == OUT_EMPTY || ren) : ren);
    assign rbin_nx   = rbin + PW'(rd_fire);

    always_comb begin
        st_nx = st;
        unique case (st)
            OUT_EMPTY: if (rd_fire) st_nx = OUT_HOLD;
            OUT_HOLD: begin
                if (rd_fire)              st_nx = OUT_HOLD;
                else if (!fwft_q || ren)  st_nx = OUT_EMPTY;
                else                      st_nx = OUT_HOLD;
            end
        endcase
    end

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) st <= OUT_EMPTY;
        else         st <= st_nx;
    end

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            rbin       <= '0;
            rgray      <= '0;
            dout       <= '0;
            pae_sync_n <= 1'b0;
            cfg_en     <= 1'b1;
        end else begin
            rbin       <= rbin_nx;
            rgray      <= rbin_nx ^ (rbin_nx >> 1);
            if (rd_fire) dout <= mem_rdata;
            pae_sync_n <= !((wbin_s - rbin_nx) <= pae_off_q);
            cfg_en     <= 1'b0;
        end
    end

    always_ff @(posedge rclk) begin
        if (cfg_en) begin
            pae_off_q   <= pae_off_in;
            fwft_q      <= fwft_in;
            flag_sync_q <= flag_sync_in;
        end
    end

    assign dout_valid = (st == OUT_HOLD);
    assign empty      = fwft_q ? (st == OUT_EMPTY) : mem_empty;

    a_r2_no_underrun: assert property (@(posedge rclk) disable iff (!mrst_n)
        (wbin_s - rbin) <= PW'(MEM));
    a_r10_rgray_step: assert property (@(posedge rclk) disable iff (!mrst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
    a_r5_fwft_hold: assert property (@(posedge rclk) disable iff (!mrst_n)
        (fwft_q && st == OUT_HOLD && !ren) |=> (st == OUT_HOLD && $stable(dout)));
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          wen,
    input  logic [DW-1:0] din,
    output logic          full,
    input  logic          ren,
    output logic [DW-1:0] dout,
    output logic          dout_valid,
    output logic          empty,
    input  logic [AW:0]   pae_off,
    input  logic [AW:0]   paf_off,
    input  logic          flag_sync_sel,
    input  logic          fwft_sel,
    output logic          pae_n,
    output logic          paf_n
);
    localparam int PW  = AW + 1;
    localparam int MEM = 1 << AW;

    logic [DW-1:0] mem [MEM];
    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray, cnt_raw, paf_off_q, pae_off_q;
    logic          wr_fire, paf_sync_n, pae_sync_n, w_sync_q, r_sync_q;
    logic [DW-1:0] mem_rdata;

    dcfifo_wside #(.AW(AW)) u_wside (
        .wclk(wclk), .mrst_n(mrst_n), .wen(wen), .paf_off_in(paf_off),
        .flag_sync_in(flag_sync_sel), .rgray(r_gray), .wbin(w_bin), .wgray(w_gray),
        .wr_fire(wr_fire), .full(full), .paf_sync_n(paf_sync_n),
        .flag_sync_q(w_sync_q), .paf_off_q(paf_off_q)
    );

    dcfifo_rside #(.DW(DW), .AW(AW)) u_rside (
        .rclk(rclk), .mrst_n(mrst_n), .ren(ren), .pae_off_in(pae_off),
        .fwft_in(fwft_sel), .flag_sync_in(flag_sync_sel), .wgray(w_gray),
        .mem_rdata(mem_rdata), .rbin(r_bin), .rgray(r_gray), .dout(dout),
        .dout_valid(dout_valid), .empty(empty), .pae_sync_n(pae_sync_n),
        .flag_sync_q(r_sync_q), .pae_off_q(pae_off_q)
    );

    always_ff @(posedge wclk) begin
        if (wr_fire) mem[w_bin[AW-1:0]] <= din;
    end
    assign mem_rdata = mem[r_bin[AW-1:0]];

    assign cnt_raw = w_bin - r_bin;
    assign pae_n   = r_sync_q ? pae_sync_n : !(cnt_raw <= pae_off_q);
    assign paf_n   = w_sync_q ? paf_sync_n : !(cnt_raw >= (PW'(MEM) - paf_off_q));
endmodule

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DW  = 8;
    localparam int AW  = 4;
    localparam int MEM = 1 << AW;
    localparam int CFG_TBL [4][4] = '{'{0, 1, 3, 2}, '{1, 1, 4, 3},
                                      '{0, 0, 5, 1}, '{1, 0, 2, 4}};

    logic wclk = 0, rclk = 0, wclk_run = 1, rclk_run = 1;
    logic mrst_n = 0, wen = 0, ren = 0, flag_sync_sel = 1, fwft_sel = 0;
    logic [DW-1:0] din = '0;
    logic [AW:0] pae_off = '0, paf_off = '0;
    logic full, empty, dout_valid, pae_n, paf_n;
    logic [DW-1:0] dout;
    int checks = 0, errors = 0;
    logic [DW-1:0] q [$];

    dcfifo_pflag #(.DW(DW), .AW(AW)) u_dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .wen(wen), .din(din),
        .full(full), .ren(ren), .dout(dout), .dout_valid(dout_valid),
        .empty(empty), .pae_off(pae_off), .paf_off(paf_off),
        .flag_sync_sel(flag_sync_sel), .fwft_sel(fwft_sel),
        .pae_n(pae_n), .paf_n(paf_n)
    );

    initial forever begin #(WCLK_PERIOD/2); if (wclk_run) wclk = ~wclk; end
    initial forever begin #(RCLK_PERIOD/2); if (rclk_run) rclk = ~rclk; end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge rclk);
        repeat (5) @(posedge wclk);
        repeat (5) @(posedge rclk);
        @(negedge wclk);
        #1;
    endtask

    task automatic do_reset(input int fw, input int sy, input int n, input int m);
        mrst_n = 0; wen = 0; ren = 0;
        fwft_sel = fw[0]; flag_sync_sel = sy[0];
        pae_off = (AW+1)'(n); paf_off = (AW+1)'(m);
        q.delete();
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        #2;
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 pae_n", pae_n, 0);
        check("R1 paf_n", paf_n, 1);
        check("R1 dout_valid", dout_valid, 0);
        @(negedge rclk);
        mrst_n = 1;
        settle();
        // R9: scramble the captured inputs; later checks expect the old values
        pae_off = (AW+1)'(n + 7); paf_off = (AW+1)'(m + 5);
        fwft_sel = ~fw[0]; flag_sync_sel = ~sy[0];
    endtask

    task automatic write_word(input logic [DW-1:0] d);
        logic was_full;
        @(negedge wclk);
        was_full = full;
        wen = 1; din = d;
        @(negedge wclk);
        wen = 0;
        if (!was_full) q.push_back(d);
    endtask

    task automatic read_word(input int fw);
        logic was_empty;
        logic [DW-1:0] exp;
        @(negedge rclk);
        if (fw != 0) begin
            if (!empty) begin
                check("R5 valid before read", dout_valid, 1);
                check("R2 order", dout, q[0]);
                ren = 1;
                @(negedge rclk);
                ren = 0;
                void'(q.pop_front());
            end
        end else begin
            was_empty = empty;
            ren = 1;
            @(negedge rclk);
            ren = 0;
            if (!was_empty) begin
                exp = q.pop_front();
                check("R2 order", dout, exp);
                check("R4 valid pulse", dout_valid, 1);
            end
        end
    endtask

    task automatic check_flags(input int w, input int fw, input int n, input int m);
        int d;
        logic pae_low, paf_low;
        d = MEM + fw;
        pae_low = (fw != 0) ? (w <= n + 1) : (w <= n);
        paf_low = (w >= d - m);
        check("R6/R9 pae_n", pae_n, !pae_low);
        check("R7/R9 paf_n", paf_n, !paf_low);
        check("R3 full", full, (w == d));
        check("R2 empty", empty, (w == 0));
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            int fw, sy, n, m, d;
            logic [DW-1:0] held;
            fw = CFG_TBL[r][0]; sy = CFG_TBL[r][1];
            n  = CFG_TBL[r][2]; m  = CFG_TBL[r][3];
            d  = MEM + fw;
            do_reset(fw, sy, n, m);
            check_flags(0, fw, n, m);
            for (int k = 0; k < d; k++) begin
                write_word(DW'(r * 40 + k + 1));
                settle();
                if (k == 0) begin
                    if (fw != 0) begin
                        check("R5 shown without read", dout_valid, 1);
                        check("R5 first word", dout, DW'(r * 40 + 1));
                    end else begin
                        check("R4 no data before read", dout_valid, 0);
                    end
                end
                check_flags(k + 1, fw, n, m);
            end
            write_word(8'hEE);   // R3: ignored while full
            settle();
            check("R3 queue size", q.size(), d);
            check_flags(d, fw, n, m);
            while (q.size() > 0) begin
                read_word(fw);
                settle();
                check_flags(q.size(), fw, n, m);
            end
            held = dout;
            read_word(fw);
            @(negedge rclk);
            check("R4 empty read no valid", dout_valid, 0);
            if (fw == 0) check("R4 empty read keeps dout", dout, held);
        end

        // R8 direct flags: move one pointer with the other clock halted
        do_reset(0, 0, 2, 2);
        write_word(8'h11); write_word(8'h12);
        settle();
        check("R8 async pae low", pae_n, 0);
        rclk_run = 0;
        write_word(8'h13);
        check("R8 async pae rises on write", pae_n, 1);
        rclk_run = 1;
        settle();
        for (int k = 0; k < 11; k++) write_word(DW'(8'h20 + k));
        settle();
        check("R8 async paf low", paf_n, 0);
        wclk_run = 0;
        read_word(0);
        check("R8 async paf rises on read", paf_n, 1);
        wclk_run = 1;
        settle();

        // R8 registered flags hold while own clock halted
        do_reset(0, 1, 2, 2);
        write_word(8'h31); write_word(8'h32);
        settle();
        rclk_run = 0;
        write_word(8'h33);
        repeat (3) @(negedge wclk);
        check("R8 sync pae holds", pae_n, 0);
        rclk_run = 1;
        settle();
        check("R8 sync pae updates", pae_n, 1);
        for (int k = 0; k < 11; k++) write_word(DW'(8'h40 + k));
        settle();
        check("R8 sync paf low", paf_n, 0);
        wclk_run = 0;
        read_word(0);
        repeat (3) @(negedge rclk);
        check("R8 sync paf holds", paf_n, 0);
        wclk_run = 1;
        settle();
        check("R8 sync paf updates", paf_n, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule